// File: doc/BRIEF.md
# XOR Lane Permuter

This block reorders the lanes of a short data vector according to an index key. The vector has a power-of-two number of lanes, W = 2^LANE_BITS, and each lane is LANE_W bits wide. For a key k, the element that enters on lane i leaves on lane i XOR k. Data is only routed. No arithmetic is done on it, and no memory is involved.

The routing network is a chain of LANE_BITS flip stages. Stage j exchanges every pair of lanes whose indices differ only in bit j, and it does so only when bit j of the key is set. When every key bit is set, every index bit is inverted, so the vector comes out in reverse order. A zero key leaves the vector as it was.

The result is held in a register with one cycle of latency. A small two-state controller tracks whether that register holds a fresh result:
- State OUT_EMPTY moves to OUT_FULL when a valid input arrives.
- State OUT_FULL stays in OUT_FULL while valid inputs keep arriving.
- State OUT_FULL returns to OUT_EMPTY on the first cycle with no valid input.
- State OUT_EMPTY stays in OUT_EMPTY while there is no valid input.

Reset places the controller in OUT_EMPTY.

Top module: `xor_lane_permuter`

## Requirements
- R1: Lane i of the vector occupies bits [i*LANE_W +: LANE_W]. One clock after a cycle with in_valid high, lane i of out_vec equals lane (i XOR in_key) of the in_vec sampled in that cycle, for every key value.
- R2: A key of zero delivers the input vector unchanged.
- R3: A key with all bits set delivers the vector reversed, so that output lane i holds input lane W-1-i.
- R4: A key with only bit j set exchanges each pair of lanes whose indices differ only in bit j, and leaves their order otherwise intact.
- R5: out_valid in each cycle equals in_valid in the previous cycle. This corresponds to the OUT_EMPTY/OUT_FULL transitions.
- R6: In a cycle with in_valid low, in_vec and in_key are ignored, and out_vec keeps its previous value on the next clock.
- R7: While rst_n is low, out_valid is 0 and out_vec is all zeros.
- R8: Each lane moves as one whole unit. All LANE_W bits of a lane arrive together in the same output lane, with their bit order unchanged.
- R9: Permuting a result a second time with the same key restores the original vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks in_vec and in_key as valid for this cycle |
| in_vec | input | (2^LANE_BITS)*LANE_W | Input vector, lane i at bits [i*LANE_W +: LANE_W] |
| in_key | input | LANE_BITS | XOR key applied to lane indices |
| out_valid | output | 1 | Registered result is fresh |
| out_vec | output | (2^LANE_BITS)*LANE_W | Registered permuted vector |

## Verification
The bench builds the block with LANE_BITS = 3 and LANE_W = 8, which gives eight byte-wide lanes and three flip stages. With only eight keys, every key can be applied directly, and each combination of active stages is exercised. Giving every lane a distinct byte makes any misrouted or split lane visible at the output. The mixed valid/idle stream drives every OUT_EMPTY/OUT_FULL transition and checks that data is held while the input is idle.

// File: rtl/xperm_pkg.sv
package xperm_pkg;

    // Occupancy of the result register.
    typedef enum logic {
        OUT_EMPTY = 1'b0,
        OUT_FULL  = 1'b1
    } xperm_state_e;

endpackage

// File: rtl/xperm_flip_stage.sv
// One index-bit flip stage. When enabled, each lane takes the data of the
// lane whose index differs from its own only in bit FLIP_BIT.
module xperm_flip_stage #(
    parameter int LANE_BITS = 3,
    parameter int LANE_W    = 8,
    parameter int FLIP_BIT  = 0
) (
    input  logic                                  en,
    input  logic [(1<<LANE_BITS)*LANE_W-1:0]      d_in,
    output logic [(1<<LANE_BITS)*LANE_W-1:0]      d_out
);
    localparam int LANES = 1 << LANE_BITS;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int PARTNER = i ^ (1 << FLIP_BIT);
        assign d_out[i*LANE_W +: LANE_W] = en ? d_in[PARTNER*LANE_W +: LANE_W]
                                              : d_in[i*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/xperm_network.sv
// A cascade of LANE_BITS flip stages, with stage j enabled by key bit j.
module xperm_network #(
    parameter int LANE_BITS = 3,
    parameter int LANE_W    = 8
) (
    input  logic [LANE_BITS-1:0]                  key,
    input  logic [(1<<LANE_BITS)*LANE_W-1:0]      d_in,
    output logic [(1<<LANE_BITS)*LANE_W-1:0]      d_out
);
    localparam int VEC_W = (1 << LANE_BITS) * LANE_W;

    logic [VEC_W-1:0] stage_bus [LANE_BITS+1];

    assign stage_bus[0] = d_in;

    for (genvar j = 0; j < LANE_BITS; j++) begin : g_stage
        xperm_flip_stage #(
            .LANE_BITS (LANE_BITS),
            .LANE_W    (LANE_W),
            .FLIP_BIT  (j)
        ) u_flip (
            .en    (key[j]),
            .d_in  (stage_bus[j]),
            .d_out (stage_bus[j+1])
        );
    end

    assign d_out = stage_bus[LANE_BITS];

endmodule

// File: rtl/xperm_out_reg.sv
// The result register and its two-state occupancy controller.
module xperm_out_reg
    import xperm_pkg::*;
#(
    parameter int VEC_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [VEC_W-1:0] d_in,
    output logic             full,
    output logic [VEC_W-1:0] q
);
    xperm_state_e state_q, state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OUT_EMPTY;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_EMPTY: if (load)  state_d = OUT_FULL;
            OUT_FULL:  if (!load) state_d = OUT_EMPTY;
        endcase
    end

    // The data register loads only when the input is valid.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d_in;
    end

    assign full = (state_q == OUT_FULL);

endmodule

// File: rtl/xor_lane_permuter.sv
module xor_lane_permuter #(
    parameter int LANE_BITS = 3,
    parameter int LANE_W    = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  in_valid,
    input  logic [(1<<LANE_BITS)*LANE_W-1:0]      in_vec,
    input  logic [LANE_BITS-1:0]                  in_key,
    output logic                                  out_valid,
    output logic [(1<<LANE_BITS)*LANE_W-1:0]      out_vec
);
    localparam int LANES = 1 << LANE_BITS;
    localparam int VEC_W = LANES * LANE_W;

    logic [VEC_W-1:0] net_out;

    xperm_network #(
        .LANE_BITS (LANE_BITS),
        .LANE_W    (LANE_W)
    ) u_net (
        .key   (in_key),
        .d_in  (in_vec),
        .d_out (net_out)
    );

    xperm_out_reg #(
        .VEC_W (VEC_W)
    ) u_oreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (in_valid),
        .d_in  (net_out),
        .full  (out_valid),
        .q     (out_vec)
    );

    // R5
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> $stable(out_vec));

    // R2
    zero_key_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && ($past(in_key) == '0))
            |-> (out_vec == $past(in_vec)));

    for (genvar i = 0; i < LANES; i++) begin : g_rev_chk
        // R3
        reverse_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(in_valid) && (&$past(in_key)))
                |-> (out_vec[i*LANE_W +: LANE_W] ==
                     $past(in_vec[(LANES-1-i)*LANE_W +: LANE_W])));
    end

endmodule

// File: tb/xor_lane_permuter_tb.sv
`timescale 1ns/1ps
module xor_lane_permuter_tb;
    localparam int N     = 3;
    localparam int LW    = 8;
    localparam int LANES = 1 << N;
    localparam int VW    = LANES * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [VW-1:0] in_vec = '0;
    logic [N-1:0]  in_key = '0;
    logic          out_valid;
    logic [VW-1:0] out_vec;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic          exp_valid = 1'b0;
    logic [VW-1:0] exp_vec   = '0;

    always #4 clk = ~clk;

    xor_lane_permuter #(.LANE_BITS(N), .LANE_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
        .in_key(in_key), .out_valid(out_valid), .out_vec(out_vec)
    );

    // Behavioural reference: output lane i takes input lane i XOR k.
    function automatic logic [VW-1:0] ref_perm(logic [VW-1:0] v, int k);
        logic [VW-1:0] r;
        for (int i = 0; i < LANES; i++) r[i*LW +: LW] = v[(i ^ k)*LW +: LW];
        return r;
    endfunction

    function automatic logic [VW-1:0] ref_rev(logic [VW-1:0] v);
        logic [VW-1:0] r;
        for (int i = 0; i < LANES; i++) r[i*LW +: LW] = v[(LANES-1-i)*LW +: LW];
        return r;
    endfunction

    function automatic logic [VW-1:0] rand_vec();
        logic [VW-1:0] r;
        for (int i = 0; i < VW; i += 32) r[i +: 32] = $urandom;
        return r;
    endfunction

    task automatic chk_eq(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s out_vec=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_model(string tag);
        tests++;
        if (out_valid !== exp_valid || out_vec !== exp_vec) begin
            fails++;
            $display("FAIL %s valid=%0b vec=%h expected valid=%0b vec=%h",
                     tag, out_valid, out_vec, exp_valid, exp_vec);
        end
    endtask

    // Drive on the falling edge, update the model at the rising edge,
    // and check 2 ns later.
    task automatic step(logic v, logic [VW-1:0] d, logic [N-1:0] k, string tag);
        @(negedge clk);
        in_valid = v; in_vec = d; in_key = k;
        @(posedge clk);
        if (v) exp_vec = ref_perm(d, int'(k));
        exp_valid = v;
        #2;
        chk_model(tag);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [VW-1:0] ramp;
        logic [VW-1:0] orig;
        logic [VW-1:0] first;

        for (int i = 0; i < LANES; i++) ramp[i*LW +: LW] = 8'hA0 + 8'(i);

        // R7: reset state, with activity on the inputs during reset
        @(negedge clk);
        in_valid = 1'b1; in_vec = ramp; in_key = 3'd5;
        repeat (3) @(posedge clk);
        #2;
        tests++;
        if (out_valid !== 1'b0 || out_vec !== '0) begin
            fails++;
            $display("FAIL R7 valid=%0b vec=%h expected valid=0 vec=0",
                     out_valid, out_vec);
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(posedge clk); #2;
        chk_model("R7 after release");

        // R2: zero key passes the vector through
        step(1'b1, ramp, 3'd0, "R2");
        chk_eq("R2 direct", out_vec, ramp);

        // R3: all-ones key reverses the vector
        step(1'b1, ramp, 3'd7, "R3");
        chk_eq("R3 direct", out_vec, ref_rev(ramp));

        // R4: single-bit keys swap the pairs that differ in that bit
        for (int j = 0; j < N; j++) step(1'b1, ramp, 3'(1 << j), "R4");

        // R1: every key value with random data
        for (int k = 0; k < LANES; k++) step(1'b1, rand_vec(), 3'(k), "R1");

        // R8: lanes with varied bit patterns stay whole
        begin
            logic [VW-1:0] pat;
            for (int i = 0; i < LANES; i++)
                pat[i*LW +: LW] = {4'(i), ~4'(i)} ^ 8'h5A;
            for (int k = 1; k < LANES; k += 2) step(1'b1, pat, 3'(k), "R8");
        end

        // R6/R5: idle cycles with changing inputs must not disturb the output
        step(1'b1, ramp, 3'd3, "R5 rise");
        for (int c = 0; c < 4; c++) step(1'b0, rand_vec(), 3'(c), "R6");
        step(1'b1, ramp, 3'd6, "R5 again");
        step(1'b0, '0, 3'd0, "R5 fall");

        // R9: a second pass with the same key restores the original vector
        for (int k = 0; k < LANES; k++) begin
            orig = rand_vec();
            step(1'b1, orig, 3'(k), "R9 first");
            first = out_vec;
            step(1'b1, first, 3'(k), "R9 second");
            chk_eq("R9 restore", out_vec, orig);
        end

        // R1/R5: random mixed stream
        for (int c = 0; c < 200; c++)
            step(1'($urandom % 2), rand_vec(), 3'($urandom), "R1 mixed");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule